// File: doc/BRIEF.md
# Over-Temperature Supervisor with Short-Circuit Foldback

This block decides, every clock cycle, whether the pass element of a pair of linear regulators may conduct. It takes a signed die temperature in whole degrees Celsius and one short-detect flag per regulator output. It drives a single enable. A flag is high while its output sits below the short threshold.

Under normal conditions the enable drops when the temperature rises above a high trip point. It comes back only after the die has cooled to a release point well below the trip point. While any output is shorted, both points move to a lower pair. This keeps the package cooler while the fault persists.

Short flags pass through a per-output persistence filter before they can select the lower pair. The trip and release pair is picked from the filtered flags in the same cycle as the comparison. A part that tripped under foldback and then loses its short therefore releases at the normal release point.

Top module: `thermal_foldback_sup`

## Requirements
- R1: While rst_n is low, pass_en_o is 0.
- R2: On the first rising clock edge after reset is released, pass_en_o becomes 1 if temp_i is at or below the active trip point, and stays 0 otherwise.
- R3: With no accepted short and the enable high, a sampled temp_i strictly above TRIP_NORM (default 170) clears pass_en_o at that edge; a temperature equal to TRIP_NORM does not.
- R4: With no accepted short and the enable low, a sampled temp_i at or below REL_NORM (default 130) sets pass_en_o at that edge; REL_NORM+1 does not.
- R5: short_i has one bit per output (bit 0 is output 0, bit 1 is output 1). The lower threshold pair applies whenever any accepted flag is 1, whichever output it belongs to.
- R6: With an accepted short and the enable high, temp_i strictly above TRIP_FOLD (default 110) clears pass_en_o; a temperature equal to TRIP_FOLD does not.
- R7: With an accepted short and the enable low, temp_i at or below REL_FOLD (default 80) sets pass_en_o; REL_FOLD+1 does not.
- R8: The threshold pair is taken from the accepted flags in the cycle of the comparison. After a foldback trip and the removal of the short, the release happens at REL_NORM.
- R9: A short flag is accepted only when its raw value has differed from the accepted value for DB_CYC consecutive sampled edges (default 4). The accepted value updates at the DB_CYC-th edge, and the comparison at the following edge uses it. A shorter pulse has no effect. Reset clears both the accepted flags and the partial counts.
- R10: temp_i is two's complement; negative temperatures lie below every threshold and never trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | TFS_TEMP_W (10) | Signed die temperature in degrees Celsius |
| short_i | input | N_OUT (2) | Raw per-output short-detect flags, 1 = shorted |
| pass_en_o | output | 1 | Pass-element enable, 1 = conduct |

## Verification
The bench sweeps temperature across each threshold at the value itself and one degree beyond it. It does this in both threshold regimes, so that a strict and a non-strict comparison give different results. Flag patterns on output 0 alone, output 1 alone, a hand-over from one output to the other, and pulses one cycle shorter than the filter length show that either output selects foldback. They also show that the filter length is exact. A foldback trip followed by removal of the short, checked one cycle before and at the acceptance edge, tells a design that latches the pair at trip time from one that picks it at comparison time. Negative readings and reset with a hot die cover the sign handling and the first-cycle decision.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    localparam int TFS_TEMP_W = 10;

    typedef logic signed [TFS_TEMP_W-1:0] tfs_temp_t;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } tfs_state_e;

    typedef struct packed {
        tfs_temp_t trip;
        tfs_temp_t rel;
    } tfs_window_t;
endpackage

// File: rtl/tfs_debounce.sv
module tfs_debounce #(
    parameter int DB_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic acc_o
);
    localparam int CNT_W = (DB_CYC < 2) ? 1 : $clog2(DB_CYC + 1);

    typedef struct packed {
        logic             acc;
        logic [CNT_W-1:0] cnt;
    } db_t;

    db_t db_d, db_q;

    always_comb begin
        db_d = db_q;
        if (raw_i == db_q.acc) begin
            db_d.cnt = '0;
        end else if (db_q.cnt == CNT_W'(DB_CYC - 1)) begin
            db_d.acc = raw_i;
            db_d.cnt = '0;
        end else begin
            db_d.cnt = db_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) db_q <= '0;
        else        db_q <= db_d;
    end

    assign acc_o = db_q.acc;

    // R9
    accept_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_q.acc) |-> ($past(raw_i) == db_q.acc));

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_q.cnt < CNT_W'(DB_CYC));
endmodule

// File: rtl/tfs_window.sv
module tfs_window
    import tfs_pkg::*;
#(
    parameter int N_OUT     = 2,
    parameter int TRIP_NORM = 170,
    parameter int REL_NORM  = 130,
    parameter int TRIP_FOLD = 110,
    parameter int REL_FOLD  = 80
) (
    input  logic [N_OUT-1:0] short_acc_i,
    output logic             fold_o,
    output tfs_window_t      win_o
);
    always_comb begin
        fold_o = |short_acc_i;
        if (fold_o) begin
            win_o.trip = tfs_temp_t'(TRIP_FOLD);
            win_o.rel  = tfs_temp_t'(REL_FOLD);
        end else begin
            win_o.trip = tfs_temp_t'(TRIP_NORM);
            win_o.rel  = tfs_temp_t'(REL_NORM);
        end
    end
endmodule

// File: rtl/tfs_trip_fsm.sv
module tfs_trip_fsm
    import tfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tfs_temp_t   temp_i,
    input  tfs_window_t win_i,
    output logic        pass_en_o
);
    typedef struct packed {
        tfs_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_INIT: fsm_d.st = (temp_i > win_i.trip) ? ST_OFF : ST_ON;
            ST_ON:   if (temp_i > win_i.trip) fsm_d.st = ST_OFF;
            ST_OFF:  if (temp_i <= win_i.rel) fsm_d.st = ST_ON;
            default: fsm_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.st <= ST_INIT;
        else        fsm_q    <= fsm_d;
    end

    assign pass_en_o = (fsm_q.st == ST_ON);

    // R2
    init_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_INIT) |=> (fsm_q.st != ST_INIT));
endmodule

// File: rtl/thermal_foldback_sup.sv
module thermal_foldback_sup
    import tfs_pkg::*;
#(
    parameter int N_OUT     = 2,
    parameter int DB_CYC    = 4,
    parameter int TRIP_NORM = 170,
    parameter int REL_NORM  = 130,
    parameter int TRIP_FOLD = 110,
    parameter int REL_FOLD  = 80
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic signed [TFS_TEMP_W-1:0] temp_i,
    input  logic [N_OUT-1:0]             short_i,
    output logic                         pass_en_o
);
    logic [N_OUT-1:0] short_acc;
    logic             fold;
    tfs_window_t      win;

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_db
        tfs_debounce #(.DB_CYC(DB_CYC)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (short_i[gi]),
            .acc_o (short_acc[gi])
        );
    end

    tfs_window #(
        .N_OUT     (N_OUT),
        .TRIP_NORM (TRIP_NORM),
        .REL_NORM  (REL_NORM),
        .TRIP_FOLD (TRIP_FOLD),
        .REL_FOLD  (REL_FOLD)
    ) u_win (
        .short_acc_i (short_acc),
        .fold_o      (fold),
        .win_o       (win)
    );

    tfs_trip_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_i    (temp_i),
        .win_i     (win),
        .pass_en_o (pass_en_o)
    );

    // R3
    norm_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en_o && !fold && temp_i > tfs_temp_t'(TRIP_NORM)) |=> !pass_en_o);

    // R4
    norm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en_o && !fold && temp_i <= tfs_temp_t'(REL_NORM)) |=> pass_en_o);

    // R6
    fold_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en_o && fold && temp_i > tfs_temp_t'(TRIP_FOLD)) |=> !pass_en_o);

    // R7
    fold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en_o && fold && temp_i <= tfs_temp_t'(REL_FOLD)) |=> pass_en_o);

    // R10
    cold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en_o && temp_i < 0) |=> pass_en_o);
endmodule

// File: tb/thermal_foldback_sup_tb.sv
module thermal_foldback_sup_tb;
    import tfs_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic signed [TFS_TEMP_W-1:0] temp_i = '0;
    logic [1:0]                   short_i = '0;
    logic                         pass_en_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    thermal_foldback_sup u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_i    (temp_i),
        .short_i   (short_i),
        .pass_en_o (pass_en_o)
    );

    localparam int NV = 20;
    localparam int V_TEMP [NV] = '{25, 170, 171, 131, 130, 150, 81, 80, 110, 111,
                                   120, 120, 120, 150, 150, 150, 150, 200, -40, -300};
    localparam int V_SH   [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 2, 2,
                                   2, 0, 0, 1, 0, 2, 0, 0, 0, 0};
    localparam int V_HOLD [NV] = '{1, 1, 1, 1, 1, 5, 1, 1, 1, 1,
                                   3, 4, 1, 3, 1, 3, 2, 1, 1, 1};
    localparam int V_EXP  [NV] = '{1, 1, 0, 0, 1, 0, 0, 1, 1, 0,
                                   0, 0, 1, 1, 1, 1, 1, 0, 1, 1};
    localparam string V_REQ [NV] = '{"R2", "R3", "R3", "R4", "R4", "R6", "R7", "R7", "R6", "R6",
                                     "R5", "R8", "R8", "R9", "R9", "R9", "R9", "R3", "R10", "R10"};

    task automatic check(input logic exp, input string req);
        n_run++;
        if (pass_en_o !== exp) begin
            n_fail++;
            $display("FAIL %s: pass_en_o=%0b expected %0b (temp=%0d short=%b)",
                     req, pass_en_o, exp, temp_i, short_i);
        end
    endtask

    task automatic apply(input int t, input int sh, input int hold);
        temp_i  = TFS_TEMP_W'(t);
        short_i = 2'(sh);
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(negedge clk);
                if (!done) begin
                    n_run++;
                    n_fail++;
                    $display("FAIL watchdog: run did not complete");
                    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                    $finish;
                end
            end
        join_none

        // R1: held in reset
        temp_i = 10'sd25;
        repeat (3) @(negedge clk);
        check(1'b0, "R1");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(V_TEMP[i], V_SH[i], V_HOLD[i]);
            check(V_EXP[i][0], V_REQ[i]);
        end

        // R1 with hot die, then R2 first-cycle decision
        rst_n = 1'b0;
        apply(200, 0, 1);
        check(1'b0, "R1");
        rst_n = 1'b1;
        apply(200, 0, 1);
        check(1'b0, "R2");
        apply(100, 0, 1);
        check(1'b1, "R4");

        // R9: reset discards a partial short count
        apply(100, 1, 3);
        rst_n = 1'b0;
        apply(100, 1, 2);
        rst_n = 1'b1;
        apply(150, 1, 1);
        check(1'b1, "R9");
        apply(150, 1, 3);
        check(1'b1, "R9");
        // R5: output 0 alone now accepted, foldback trips
        apply(150, 1, 1);
        check(1'b0, "R5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule